// File: doc/BRIEF.md
# Pipeline Hazard Detect and Forward Unit

This block holds the hazard control for an in-order pipeline with five stages: fetch, decode, execute, memory and write-back. When there are no hazards, the pipeline completes one instruction per clock. The block is purely combinational. Each cycle, the surrounding datapath presents the register indices and write enables of the instructions in its stage registers. The block returns four groups of controls in that same cycle:

- Operand-source selects for the two ALU inputs in execute.
- Write-first bypass selects for the two register-file reads in decode.
- A hold of the PC and the fetch/decode register, together with a bubble into decode/execute, when a load result is needed too early.
- Flushes of the two youngest stage registers when a branch or jump taken in execute redirects fetch.

Most read-after-write dependences are resolved by forwarding. Only a load whose data is not yet available forces a hold, and that hold freezes every younger instruction behind it. Reads that follow reads never cost a cycle.

Top module: `hzu_top`

## Requirements
- R1: When the memory-stage instruction writes a nonzero register equal to an execute source, that operand's select is 2'b10 (take the memory-stage result).
- R2: When only the write-back-stage instruction writes a nonzero register equal to an execute source, the select is 2'b01. When both later stages match, 2'b10 wins. With no match, the select is 2'b00 (register file).
- R3: Register index 0 is never forwarded, never bypassed and never causes a hold, whatever the write enables.
- R4: A stage whose write enable is low never produces a forward, a bypass or a hold, even when its index matches (read after read is no hazard).
- R5: A load in execute (load flag and write enable high) whose nonzero destination equals either decode source raises pc_hold, ifid_hold and idex_bubble together in that cycle.
- R6: Once the load has moved on and execute holds a bubble, the hold drops, so a load-use dependence costs exactly one cycle. The dependent instruction then takes its operand with select 2'b01.
- R7: A non-load instruction in execute whose destination matches a decode source causes no hold.
- R8: When branch_taken is high, ifid_flush and idex_flush are high, and pc_hold, ifid_hold and idex_bubble are low.
- R9: When the write-back instruction writes a nonzero register that equals a decode source, that source's bypass output is 1, so the read returns the value being written.
- R10: The select code 2'b11 never appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| id_rs1 | input | 5 | First source index of the instruction in decode |
| id_rs2 | input | 5 | Second source index of the instruction in decode |
| ex_rs1 | input | 5 | First source index of the instruction in execute |
| ex_rs2 | input | 5 | Second source index of the instruction in execute |
| ex_rd | input | 5 | Destination index of the instruction in execute |
| ex_we | input | 1 | Execute instruction writes a register |
| ex_load | input | 1 | Execute instruction reads data memory |
| mem_rd | input | 5 | Destination index of the instruction in memory |
| mem_we | input | 1 | Memory instruction writes a register |
| wb_rd | input | 5 | Destination index of the instruction in write-back |
| wb_we | input | 1 | Write-back instruction writes a register |
| branch_taken | input | 1 | Branch or jump in execute redirects fetch |
| fwd_a | output | 2 | Source for ALU operand A: 00 file, 01 write-back, 10 memory |
| fwd_b | output | 2 | Source for ALU operand B, same coding |
| byp_rs1 | output | 1 | Decode read 1 takes the write-back value |
| byp_rs2 | output | 1 | Decode read 2 takes the write-back value |
| pc_hold | output | 1 | Keep the PC unchanged this cycle |
| ifid_hold | output | 1 | Keep the fetch/decode register unchanged |
| idex_bubble | output | 1 | Load a bubble into decode/execute |
| ifid_flush | output | 1 | Turn the fetch/decode register into a bubble |
| idex_flush | output | 1 | Turn the decode/execute register into a bubble |

## Verification
Every output of this block is due in the same cycle as the stage contents that cause it: no register lies between inputs and outputs. The bench therefore drives each set of stage contents just after a falling edge and samples one nanosecond later, well before the next rising edge. The one multi-cycle behaviour is that a load-use hold lasts a single cycle. It is checked by advancing the modelled pipeline one cycle at a time. The load moves to memory while a bubble enters execute, and then the held instruction moves to execute. The hold is checked low in the second cycle, and the write-back select is checked in the third.

// File: rtl/hzu_pkg.sv
package hzu_pkg;

    localparam int REG_IDX_W = 5;
    localparam int NUM_SRC   = 2;

    typedef logic [REG_IDX_W-1:0] reg_idx_t;

    typedef enum logic [1:0] {
        SRC_FILE = 2'b00,
        SRC_WB   = 2'b01,
        SRC_MEM  = 2'b10
    } opnd_src_e;

    typedef struct packed {
        logic     we;
        reg_idx_t idx;
    } dest_tag_t;

    // A later stage supplies a source only if it really writes a nonzero register
    function automatic logic tag_hits(dest_tag_t t, reg_idx_t src);
        return t.we && (t.idx != '0) && (t.idx == src);
    endfunction

endpackage

// File: rtl/hzu_opnd_select.sv
module hzu_opnd_select
    import hzu_pkg::*;
(
    input  reg_idx_t  src,
    input  dest_tag_t mem_tag,
    input  dest_tag_t wb_tag,
    output opnd_src_e sel
);
    always_comb begin
        if (tag_hits(mem_tag, src))
            sel = SRC_MEM;
        else if (tag_hits(wb_tag, src))
            sel = SRC_WB;
        else
            sel = SRC_FILE;
    end
endmodule

// File: rtl/hzu_rf_bypass.sv
module hzu_rf_bypass
    import hzu_pkg::*;
(
    input  reg_idx_t  src,
    input  dest_tag_t wb_tag,
    output logic      take_wb
);
    assign take_wb = tag_hits(wb_tag, src);
endmodule

// File: rtl/hzu_load_guard.sv
module hzu_load_guard
    import hzu_pkg::*;
(
    input  reg_idx_t  id_src [NUM_SRC],
    input  dest_tag_t ex_tag,
    input  logic      ex_load,
    input  logic      redirect,
    output logic      stall
);
    logic [NUM_SRC-1:0] hit;

    for (genvar s = 0; s < NUM_SRC; s++) begin : g_cmp
        assign hit[s] = tag_hits(ex_tag, id_src[s]);
    end

    // A redirect discards the decode instruction, so waiting for it is pointless
    assign stall = ex_load && (|hit) && !redirect;

    always_comb begin
        // R3
        load_r0_chk: assert (!(stall && ex_tag.idx == '0));
    end
endmodule

// File: rtl/hzu_top.sv
module hzu_top
    import hzu_pkg::*;
(
    input  logic [4:0] id_rs1,
    input  logic [4:0] id_rs2,
    input  logic [4:0] ex_rs1,
    input  logic [4:0] ex_rs2,
    input  logic [4:0] ex_rd,
    input  logic       ex_we,
    input  logic       ex_load,
    input  logic [4:0] mem_rd,
    input  logic       mem_we,
    input  logic [4:0] wb_rd,
    input  logic       wb_we,
    input  logic       branch_taken,
    output logic [1:0] fwd_a,
    output logic [1:0] fwd_b,
    output logic       byp_rs1,
    output logic       byp_rs2,
    output logic       pc_hold,
    output logic       ifid_hold,
    output logic       idex_bubble,
    output logic       ifid_flush,
    output logic       idex_flush
);
    reg_idx_t  id_src [NUM_SRC];
    reg_idx_t  ex_src [NUM_SRC];
    opnd_src_e sel    [NUM_SRC];
    logic [NUM_SRC-1:0] byp;
    dest_tag_t ex_tag, mem_tag, wb_tag;
    logic      load_stall;

    assign id_src[0] = id_rs1;
    assign id_src[1] = id_rs2;
    assign ex_src[0] = ex_rs1;
    assign ex_src[1] = ex_rs2;
    assign ex_tag    = '{we: ex_we,  idx: ex_rd};
    assign mem_tag   = '{we: mem_we, idx: mem_rd};
    assign wb_tag    = '{we: wb_we,  idx: wb_rd};

    for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
        hzu_opnd_select u_sel (
            .src     (ex_src[s]),
            .mem_tag (mem_tag),
            .wb_tag  (wb_tag),
            .sel     (sel[s])
        );
        hzu_rf_bypass u_byp (
            .src     (id_src[s]),
            .wb_tag  (wb_tag),
            .take_wb (byp[s])
        );
    end

    hzu_load_guard u_guard (
        .id_src   (id_src),
        .ex_tag   (ex_tag),
        .ex_load  (ex_load),
        .redirect (branch_taken),
        .stall    (load_stall)
    );

    assign fwd_a       = sel[0];
    assign fwd_b       = sel[1];
    assign byp_rs1     = byp[0];
    assign byp_rs2     = byp[1];
    assign pc_hold     = load_stall;
    assign ifid_hold   = load_stall;
    assign idex_bubble = load_stall;
    assign ifid_flush  = branch_taken;
    assign idex_flush  = branch_taken;

    always_comb begin
        // R10
        fwd_code_chk: assert (fwd_a != 2'b11 && fwd_b != 2'b11);
        // R3
        r0_fwd_chk: assert (!(ex_rs1 == '0 && fwd_a != 2'b00));
        // R4
        mem_we_fwd_chk: assert (!(fwd_a == 2'b10 && !mem_we));
        // R8
        flush_no_hold_chk: assert (!(ifid_flush && (pc_hold || idex_bubble)));
        // R5
        hold_group_chk: assert (pc_hold == ifid_hold && ifid_hold == idex_bubble);
        // R9
        byp_r0_chk: assert (!(byp_rs1 && id_rs1 == '0));
    end
endmodule

// File: tb/hzu_top_test.sv
module hzu_top_test;
    logic       clk = 1'b0;
    logic [4:0] id_rs1, id_rs2, ex_rs1, ex_rs2, ex_rd, mem_rd, wb_rd;
    logic       ex_we, ex_load, mem_we, wb_we, branch_taken;
    logic [1:0] fwd_a, fwd_b;
    logic       byp_rs1, byp_rs2, pc_hold, ifid_hold, idex_bubble, ifid_flush, idex_flush;
    int         n_chk = 0;
    int         n_bad = 0;

    always #5 clk = ~clk;

    hzu_top uut (
        .id_rs1(id_rs1), .id_rs2(id_rs2), .ex_rs1(ex_rs1), .ex_rs2(ex_rs2),
        .ex_rd(ex_rd), .ex_we(ex_we), .ex_load(ex_load),
        .mem_rd(mem_rd), .mem_we(mem_we), .wb_rd(wb_rd), .wb_we(wb_we),
        .branch_taken(branch_taken),
        .fwd_a(fwd_a), .fwd_b(fwd_b), .byp_rs1(byp_rs1), .byp_rs2(byp_rs2),
        .pc_hold(pc_hold), .ifid_hold(ifid_hold), .idex_bubble(idex_bubble),
        .ifid_flush(ifid_flush), .idex_flush(idex_flush)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic idle();
        id_rs1 = 0; id_rs2 = 0; ex_rs1 = 0; ex_rs2 = 0; ex_rd = 0;
        ex_we = 0; ex_load = 0; mem_rd = 0; mem_we = 0; wb_rd = 0; wb_we = 0;
        branch_taken = 0;
    endtask

    // next cycle: drive after the falling edge, outputs sampled 1 ns later
    task automatic step();
        @(negedge clk);
    endtask

    task automatic settle();
        #1;
    endtask

    function automatic logic [2:0] holds();
        return {pc_hold, ifid_hold, idex_bubble};
    endfunction

    task automatic t_reset_state();
        step(); idle(); settle();
        check("R2 idle fwd", {fwd_b, fwd_a}, 8'h0);
        check("R8 idle ctrl", {holds(), ifid_flush, idex_flush, byp_rs1, byp_rs2}, 8'h0);
    endtask

    task automatic t_mem_fwd();
        step(); idle();
        ex_rs1 = 5'd7; ex_rs2 = 5'd9; mem_rd = 5'd7; mem_we = 1; settle();
        check("R1 mem fwd A", fwd_a, 8'h2);
        check("R1 no fwd B", fwd_b, 8'h0);
    endtask

    task automatic t_wb_and_priority();
        step(); idle();
        ex_rs1 = 5'd4; ex_rs2 = 5'd4; wb_rd = 5'd4; wb_we = 1; settle();
        check("R2 wb fwd A", fwd_a, 8'h1);
        check("R2 wb fwd B", fwd_b, 8'h1);
        step(); mem_rd = 5'd4; mem_we = 1; settle();
        check("R2 mem over wb", {fwd_b, fwd_a}, 8'hA);
    endtask

    task automatic t_reg_zero();
        step(); idle();
        ex_rs1 = 0; ex_rs2 = 0; mem_rd = 0; mem_we = 1; wb_rd = 0; wb_we = 1;
        id_rs1 = 0; ex_rd = 0; ex_we = 1; ex_load = 1; settle();
        check("R3 r0 fwd", {fwd_b, fwd_a}, 8'h0);
        check("R3 r0 bypass", byp_rs1, 8'h0);
        check("R3 r0 hold", holds(), 8'h0);
    endtask

    task automatic t_no_write();
        step(); idle();
        ex_rs1 = 5'd3; mem_rd = 5'd3; wb_rd = 5'd3; id_rs2 = 5'd3;
        ex_rd = 5'd3; ex_load = 1; settle();
        check("R4 no we fwd", fwd_a, 8'h0);
        check("R4 no we bypass", byp_rs2, 8'h0);
        check("R4 no we hold", holds(), 8'h0);
    endtask

    task automatic t_load_use_one_cycle();
        // cycle 1: load r8 in EX, decode reads r8 as second source
        step(); idle();
        id_rs1 = 5'd2; id_rs2 = 5'd8; ex_rd = 5'd8; ex_we = 1; ex_load = 1; settle();
        check("R5 load-use hold", holds(), 8'h7);
        check("R5 no flush", {ifid_flush, idex_flush}, 8'h0);
        // cycle 2: load in MEM, bubble in EX, decode unchanged
        step();
        ex_rd = 0; ex_we = 0; ex_load = 0; mem_rd = 5'd8; mem_we = 1; settle();
        check("R6 hold released", holds(), 8'h0);
        // cycle 3: dependent in EX, load in WB
        step();
        ex_rs1 = 5'd2; ex_rs2 = 5'd8; mem_rd = 0; mem_we = 0; wb_rd = 5'd8; wb_we = 1;
        id_rs1 = 5'd11; id_rs2 = 5'd12; settle();
        check("R6 wb fwd after stall", fwd_b, 8'h1);
        // first source also triggers
        step(); idle();
        id_rs1 = 5'd15; ex_rd = 5'd15; ex_we = 1; ex_load = 1; settle();
        check("R5 load-use rs1", holds(), 8'h7);
    endtask

    task automatic t_alu_no_stall();
        step(); idle();
        id_rs1 = 5'd6; ex_rd = 5'd6; ex_we = 1; ex_load = 0; settle();
        check("R7 alu no hold", holds(), 8'h0);
    endtask

    task automatic t_branch();
        step(); idle();
        branch_taken = 1; settle();
        check("R8 flush", {ifid_flush, idex_flush}, 8'h3);
        step();
        id_rs1 = 5'd5; ex_rd = 5'd5; ex_we = 1; ex_load = 1; settle();
        check("R8 flush beats hold", {holds(), ifid_flush}, 8'h1);
        step(); branch_taken = 0; settle();
        check("R8 flush clears", {ifid_flush, idex_flush}, 8'h0);
    endtask

    task automatic t_bypass();
        step(); idle();
        id_rs1 = 5'd20; id_rs2 = 5'd21; wb_rd = 5'd21; wb_we = 1; settle();
        check("R9 bypass rs2", {byp_rs1, byp_rs2}, 8'h1);
        step(); id_rs1 = 5'd21; settle();
        check("R9 bypass both", {byp_rs1, byp_rs2}, 8'h3);
    endtask

    task automatic t_codes();
        for (int r = 1; r < 32; r += 5) begin
            step(); idle();
            ex_rs1 = r[4:0]; ex_rs2 = r[4:0]; mem_rd = r[4:0]; mem_we = 1;
            wb_rd = r[4:0]; wb_we = 1; settle();
            check("R10 legal code", {6'd0, fwd_a == 2'b11 || fwd_b == 2'b11}, 8'h0);
        end
    endtask

    initial begin
        idle();
        t_reset_state();
        t_mem_fwd();
        t_wb_and_priority();
        t_reg_zero();
        t_no_write();
        t_load_use_one_cycle();
        t_alu_no_stall();
        t_branch();
        t_bypass();
        t_codes();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule